// File: doc/BRIEF.md
# Hall Sensor Commutation Timer

This block watches the three Hall sensor lines of a brushless motor. It synchronises and deglitches each line, and it keeps a counter for every phase that measures the cycles since that phase last changed. A free-running timer runs beside them. For every phase it records the length of the last high-going interval and the last low-going interval. It works out the rotation direction from the order of the sensor states. It raises events on sensor changes, on an early warning before the expected next change, on a programmable delay, and on a stall timeout.

Firmware programs and reads it through a simple word-addressed write/read port. Every event has four enable masks. Three of them drive the interrupt, DMA request and trigger outputs. The fourth makes the hardware copy all counts into a read bank. Two external strobes copy all counts into two snapshot banks.

Top module: `hall_commutation_timer`

## Requirements
- R1: Each sensor line passes a two-flop synchroniser and a filter. A level that holds for fewer than FILT_LEN (default 3) consecutive cycles is ignored: no state change and no toggle flag.
- R2: Counts are read at word address 0x10+i, with i=0 for W, 1 for V, 2 for U and 3 for the timer, in the low CW bits. The U word (0x12) also carries the direction in bit 31 and the filtered state {U,V,W} in bits 30:28, with W in bit 28.
- R3: The forward order is 001, 011, 010, 110, 100, 101 and back to 001 (as {U,V,W}). A step along that order sets the direction to 0; a step against it sets it to 1. Any change that starts or ends in 000 or 111 leaves the direction unchanged.
- R4: For phase i, address 0x20+2i holds the phase count at its last 0-to-1 change and 0x21+2i holds it at its last 1-to-0 change. Both equal the number of cycles since the previous change of that phase.
- R5: The status word (0x06) sets bit 31 on stall, bit 30 on any change, bit 29 on the early trigger, bit 28 on delay done, and bits 23, 22 and 21 on a U, V or W toggle. Flags stay set until a 1 is written to their bit.
- R6: irq, dma_req and trig_out are each the OR of the status bits that are also set in their mask (0x07, 0x08 and 0x09).
- R7: Writing bit 2 of the control word (0x00) copies all four counts into the read bank (0x14+i). The bit clears itself and reads back as 0. Any event enabled in the read mask (0x0A) copies the counts the same way.
- R8: When control bit 1 is set, a pulse on snap_a copies the four counts into bank 0x18+i and a pulse on snap_b copies them into bank 0x1C+i. When bit 1 is clear, the strobes have no effect.
- R9: While control bit 0 is high, all counters, histories and banks read zero. Counting restarts when the bit is released.
- R10: With the stall enable (0x05 bit 0) set, the stall flag rises once the timeout (0x04) has passed in cycles without any sensor change. Each change restarts the timeout.
- R11: The early trigger fires once per interval, when the time since the last change equals the previous interval minus the early count (0x03). It fires only if the previous interval is longer than the early count.
- R12: The delay event fires the delay count (0x01) plus one cycles after its start point. Select bit 0 of 0x02 picks the start point: 0 for any sensor change, 1 for the early trigger.
- R13: The timer rises by one every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_in | input | 3 | Sensor lines {U,V,W} |
| snap_a | input | 1 | Snapshot strobe for bank A |
| snap_b | input | 1 | Snapshot strobe for bank B |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after addr |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| trig_out | output | 1 | Trigger output |

## Verification
The bench walks the direction logic through a detour across the invalid state 111. A design that compared across the invalid state would report reverse instead of forward. Random steps forward and backward then check the direction bit after every step.

Edge histories are checked against exact edge spacing, so an off-by-one in the restart value shows up. Timer readings taken a known number of cycles apart are compared exactly.

The delay select is tested with a window where a change-started delay would already have fired but a trigger-started one has not. The early trigger is tested with an early count larger than the interval, which must stay silent.

A one-cycle glitch must leave the state and the flags untouched. A selective write-one-to-clear must leave the other flags set.

// File: rtl/hct_pkg.sv
package hct_pkg;
  localparam int ADDR_W = 6;
  localparam int NPH    = 3;
  localparam int NCNT   = 4;

  localparam int EV_STALL = 31;
  localparam int EV_CHG   = 30;
  localparam int EV_EARLY = 29;
  localparam int EV_DLY   = 28;
  localparam int EV_U     = 23;
  localparam int EV_V     = 22;
  localparam int EV_W     = 21;
  localparam logic [31:0] EV_ALL = 32'hF0E0_0000;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_DLY    = 6'h01;
  localparam logic [ADDR_W-1:0] A_DSEL   = 6'h02;
  localparam logic [ADDR_W-1:0] A_EARLY  = 6'h03;
  localparam logic [ADDR_W-1:0] A_STTO   = 6'h04;
  localparam logic [ADDR_W-1:0] A_STEN   = 6'h05;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h06;
  localparam logic [ADDR_W-1:0] A_IRQM   = 6'h07;
  localparam logic [ADDR_W-1:0] A_DMAM   = 6'h08;
  localparam logic [ADDR_W-1:0] A_TRGM   = 6'h09;
  localparam logic [ADDR_W-1:0] A_RDM    = 6'h0A;

  function automatic logic [2:0] fwd_next(input logic [2:0] s);
    case (s)
      3'b001:  return 3'b011;
      3'b011:  return 3'b010;
      3'b010:  return 3'b110;
      3'b110:  return 3'b100;
      3'b100:  return 3'b101;
      3'b101:  return 3'b001;
      default: return s;
    endcase
  endfunction

  function automatic logic is_valid(input logic [2:0] s);
    return (s != 3'b000) && (s != 3'b111);
  endfunction
endpackage

// File: rtl/hct_in_filter.sv
module hct_in_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int RW = $clog2(FILT_LEN) + 1;

  logic [1:0]    sy;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy   <= '0;
      dout <= 1'b0;
      run  <= '0;
    end else begin
      sy <= {sy[0], din};
      if (sy[1] != dout) begin
        if (run == RW'(FILT_LEN - 1)) begin
          dout <= sy[1];
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end

  // R1: the filtered level only follows a differing synchronised level
  p_filter_follows_r1: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(sy[1]) != $past(dout)));
endmodule

// File: rtl/hct_count_core.sv
module hct_count_core
  import hct_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hold,
  input  logic [NPH-1:0]            state,
  input  logic                      snap_en,
  input  logic                      snap_a,
  input  logic                      snap_b,
  input  logic                      rd_load,
  output logic [NCNT-1:0][CW-1:0]   cur,
  output logic [NCNT-1:0][CW-1:0]   rdb,
  output logic [NCNT-1:0][CW-1:0]   snpa,
  output logic [NCNT-1:0][CW-1:0]   snpb,
  output logic [NPH-1:0][CW-1:0]    hist_r,
  output logic [NPH-1:0][CW-1:0]    hist_f,
  output logic                      dir,
  output logic                      chg,
  output logic [NPH-1:0]            tog
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [NPH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= state;
  end

  assign tog = state ^ prev;
  assign chg = |tog;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst || hold) begin
        cur[p]    <= '0;
        hist_r[p] <= '0;
        hist_f[p] <= '0;
      end else if (tog[p]) begin
        if (state[p]) hist_r[p] <= cur[p];
        else          hist_f[p] <= cur[p];
        cur[p] <= CW'(1);
      end else if (cur[p] != CMAX) begin
        cur[p] <= cur[p] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) cur[NCNT-1] <= '0;
    else             cur[NCNT-1] <= cur[NCNT-1] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      rdb  <= '0;
      snpa <= '0;
      snpb <= '0;
    end else begin
      if (rd_load)          rdb  <= cur;
      if (snap_en && snap_a) snpa <= cur;
      if (snap_en && snap_b) snpb <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir <= 1'b0;
    end else if (chg && is_valid(prev) && is_valid(state)) begin
      if (state == fwd_next(prev))      dir <= 1'b0;
      else if (prev == fwd_next(state)) dir <= 1'b1;
    end
  end

  // R3: direction moves only on a registered state change
  p_dir_on_change_r3: assert property (@(posedge clk) disable iff (rst)
    (dir != $past(dir)) |-> $past(chg));

  // R9: counter hold clears the timer and every capture bank
  p_hold_zero_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cur[NCNT-1] == '0 && rdb == '0 && snpa == '0 && snpb == '0));
endmodule

// File: rtl/hct_event_gen.sv
module hct_event_gen #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chg,
  input  logic [CW-1:0] dly_cnt,
  input  logic          dly_sel,
  input  logic [CW-1:0] early_cnt,
  input  logic [CW-1:0] stall_to,
  input  logic          stall_en,
  output logic          early_ev,
  output logic          dly_ev,
  output logic          stall_ev
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] since, last_ivl, dcnt, wcnt;
  logic          early_done, armed;
  logic          early_fire, dstart, dfire, wfire;

  always_comb begin
    early_fire = !early_done && !chg && (last_ivl > early_cnt)
                 && (since == last_ivl - early_cnt);
    dstart     = dly_sel ? early_fire : chg;
    dfire      = armed && !dstart && (dcnt == '0);
    wfire      = stall_en && !chg && (stall_to != '0) && (wcnt == stall_to - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since      <= '0;
      last_ivl   <= '0;
      early_done <= 1'b0;
      dcnt       <= '0;
      armed      <= 1'b0;
      wcnt       <= '0;
      early_ev   <= 1'b0;
      dly_ev     <= 1'b0;
      stall_ev   <= 1'b0;
    end else begin
      if (chg) begin
        last_ivl   <= since;
        since      <= CW'(1);
        early_done <= 1'b0;
      end else begin
        if (since != CMAX) since <= since + 1'b1;
        if (early_fire)    early_done <= 1'b1;
      end

      if (dstart) begin
        dcnt  <= dly_cnt;
        armed <= 1'b1;
      end else if (armed) begin
        if (dcnt == '0) armed <= 1'b0;
        else            dcnt  <= dcnt - 1'b1;
      end

      if (!stall_en || chg)     wcnt <= '0;
      else if (wcnt < stall_to) wcnt <= wcnt + 1'b1;

      early_ev <= early_fire;
      dly_ev   <= dfire;
      stall_ev <= wfire;
    end
  end

  // R11: at most one early trigger per interval, so never two in a row
  p_early_single_r11: assert property (@(posedge clk) disable iff (rst)
    early_ev |=> !early_ev);

  // R10: the stall event never follows a cycle that saw a sensor change
  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    stall_ev |-> !$past(chg));
endmodule

// File: rtl/hall_commutation_timer.sv
module hall_commutation_timer
  import hct_pkg::*;
#(
  parameter int CW       = 24,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        hall_in,
  input  logic              snap_a,
  input  logic              snap_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              dma_req,
  output logic              trig_out
);
  logic [NPH-1:0] state, tog;
  logic           dir, chg;
  logic           early_ev, dly_ev, stall_ev;

  logic [NCNT-1:0][CW-1:0] cur, rdb, snpa, snpb;
  logic [NPH-1:0][CW-1:0]  hist_r, hist_f;

  logic          ctrl_hold, ctrl_snap, dly_sel, stall_en;
  logic [CW-1:0] dly_cnt, early_cnt, stall_to;
  logic [31:0]   status, irq_m, dma_m, trg_m, rd_m;
  logic [31:0]   ev, w1c, rd_mux;
  logic          sw_load, rd_load;

  for (genvar i = 0; i < NPH; i++) begin : g_in
    hct_in_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (hall_in[i]),
      .dout(state[i])
    );
  end

  hct_count_core #(.CW(CW)) u_core (
    .clk    (clk),
    .rst    (rst),
    .hold   (ctrl_hold),
    .state  (state),
    .snap_en(ctrl_snap),
    .snap_a (snap_a),
    .snap_b (snap_b),
    .rd_load(rd_load),
    .cur    (cur),
    .rdb    (rdb),
    .snpa   (snpa),
    .snpb   (snpb),
    .hist_r (hist_r),
    .hist_f (hist_f),
    .dir    (dir),
    .chg    (chg),
    .tog    (tog)
  );

  hct_event_gen #(.CW(CW)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .chg      (chg),
    .dly_cnt  (dly_cnt),
    .dly_sel  (dly_sel),
    .early_cnt(early_cnt),
    .stall_to (stall_to),
    .stall_en (stall_en),
    .early_ev (early_ev),
    .dly_ev   (dly_ev),
    .stall_ev (stall_ev)
  );

  always_comb begin
    ev           = '0;
    ev[EV_STALL] = stall_ev;
    ev[EV_CHG]   = chg;
    ev[EV_EARLY] = early_ev;
    ev[EV_DLY]   = dly_ev;
    ev[EV_U]     = tog[2];
    ev[EV_V]     = tog[1];
    ev[EV_W]     = tog[0];
    w1c          = (wr_en && addr == A_STATUS) ? wdata : '0;
    sw_load      = wr_en && (addr == A_CTRL) && wdata[2];
    rd_load      = sw_load || |(ev & rd_m);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_hold <= 1'b0;
      ctrl_snap <= 1'b0;
      dly_cnt   <= '0;
      dly_sel   <= 1'b0;
      early_cnt <= '0;
      stall_to  <= '0;
      stall_en  <= 1'b0;
      irq_m     <= '0;
      dma_m     <= '0;
      trg_m     <= '0;
      rd_m      <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  begin ctrl_hold <= wdata[0]; ctrl_snap <= wdata[1]; end
        A_DLY:   dly_cnt   <= wdata[CW-1:0];
        A_DSEL:  dly_sel   <= wdata[0];
        A_EARLY: early_cnt <= wdata[CW-1:0];
        A_STTO:  stall_to  <= wdata[CW-1:0];
        A_STEN:  stall_en  <= wdata[0];
        A_IRQM:  irq_m     <= wdata & EV_ALL;
        A_DMAM:  dma_m     <= wdata & EV_ALL;
        A_TRGM:  trg_m     <= wdata & EV_ALL;
        A_RDM:   rd_m      <= wdata & EV_ALL;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      irq      <= 1'b0;
      dma_req  <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      status   <= ((status & ~w1c) | ev) & EV_ALL;
      irq      <= |(status & irq_m);
      dma_req  <= |(status & dma_m);
      trig_out <= |(status & trg_m);
    end
  end

  function automatic logic [31:0] ext(input logic [CW-1:0] v);
    return {{(32 - CW){1'b0}}, v};
  endfunction

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:   rd_mux = {30'b0, ctrl_snap, ctrl_hold};
      A_DLY:    rd_mux = ext(dly_cnt);
      A_DSEL:   rd_mux = {31'b0, dly_sel};
      A_EARLY:  rd_mux = ext(early_cnt);
      A_STTO:   rd_mux = ext(stall_to);
      A_STEN:   rd_mux = {31'b0, stall_en};
      A_STATUS: rd_mux = status;
      A_IRQM:   rd_mux = irq_m;
      A_DMAM:   rd_mux = dma_m;
      A_TRGM:   rd_mux = trg_m;
      A_RDM:    rd_mux = rd_m;
      default:  ;
    endcase
    if (addr[5:4] == 2'b01) begin
      case (addr[3:2])
        2'd0:    rd_mux = ext(cur[addr[1:0]]);
        2'd1:    rd_mux = ext(rdb[addr[1:0]]);
        2'd2:    rd_mux = ext(snpa[addr[1:0]]);
        default: rd_mux = ext(snpb[addr[1:0]]);
      endcase
      if (addr[3:0] == 4'h2) rd_mux[31:28] = {dir, state};
    end
    if (addr[5:3] == 3'b100 && addr[2:1] != 2'd3) begin
      rd_mux = addr[0] ? ext(hist_f[addr[2:1]]) : ext(hist_r[addr[2:1]]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R5: the stall flag drops only through a write of one to its bit
  p_w1c_only_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(status[EV_STALL]) |-> $past(wr_en && addr == A_STATUS && wdata[EV_STALL]));
endmodule

// File: tb/hall_commutation_timer_test.sv
module hall_commutation_timer_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  hall_in = 3'b000;
  logic        snap_a = 1'b0, snap_b = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, dma_req, trig_out;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [5:0] R_CTRL = 6'h00, R_DLY = 6'h01, R_DSEL = 6'h02, R_EARLY = 6'h03;
  localparam logic [5:0] R_STTO = 6'h04, R_STEN = 6'h05, R_ST = 6'h06, R_IRQM = 6'h07;
  localparam logic [5:0] R_DMAM = 6'h08, R_TRGM = 6'h09, R_RDM = 6'h0A;
  localparam logic [5:0] R_UWORD = 6'h12, R_TMR = 6'h13, R_RDTMR = 6'h17;
  localparam logic [5:0] R_SATMR = 6'h1B, R_SBTMR = 6'h1F, R_URISE = 6'h24, R_UFALL = 6'h25;

  always #(CLK_P / 2) clk = ~clk;

  hall_commutation_timer uut (
    .clk(clk), .rst(rst), .hall_in(hall_in), .snap_a(snap_a), .snap_b(snap_b),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .dma_req(dma_req), .trig_out(trig_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk);
    @(negedge clk); d = rdata;
  endtask

  task automatic hall(input logic [2:0] v);
    @(negedge clk); hall_in = v;
  endtask

  function automatic logic [2:0] step(input logic [2:0] s, input bit fw);
    logic [2:0] ring [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    for (int k = 0; k < 6; k++)
      if (ring[k] == s) return fw ? ring[(k + 1) % 6] : ring[(k + 5) % 6];
    return s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, a, b;
    logic [2:0]  s;
    void'($urandom(32'd4242));
    cyc(5); rst = 1'b0; cyc(2);

    // reset state
    rd(R_ST, d); chk("R5 reset status", d, 0);
    chk("R6 reset irq", irq, 0); chk("R6 reset dma", dma_req, 0); chk("R6 reset trg", trig_out, 0);

    // state and direction
    hall(3'b001); cyc(12); rd(R_UWORD, d); chk("R2 state bits", d[30:28], 3'b001);
    chk("R3 dir after invalid start", d[31], 0);
    hall(3'b011); cyc(12); rd(R_UWORD, d); chk("R3 forward", d[31], 0);
    hall(3'b001); cyc(12); rd(R_UWORD, d); chk("R3 reverse", d[31], 1);
    hall(3'b011); cyc(12); rd(R_UWORD, d); chk("R3 forward again", d[31], 0);
    hall(3'b111); cyc(12); rd(R_UWORD, d); chk("R2 invalid state shown", d[30:28], 3'b111);
    hall(3'b001); cyc(12); rd(R_UWORD, d); chk("R3 invalid detour ignored", d[31], 0);

    // glitch filter
    wr(R_ST, 32'hFFFF_FFFF); cyc(3); wr(R_ST, 32'hFFFF_FFFF);
    hall(3'b101); hall(3'b001); cyc(12);
    rd(R_ST, d); chk("R1 glitch no flag", d & 32'h40E0_0000, 0);
    rd(R_UWORD, d); chk("R1 glitch no state", d[30:28], 3'b001);

    // status flags and W1C
    hall(3'b101); cyc(12);
    rd(R_ST, d); chk("R5 U toggle flags", d & 32'h40E0_0000, 32'h4080_0000);
    wr(R_ST, 32'h0080_0000);
    rd(R_ST, d); chk("R5 selective clear", d & 32'h40E0_0000, 32'h4000_0000);

    // output masks
    wr(R_IRQM, 32'h4000_0000); cyc(2);
    chk("R6 irq on", irq, 1); chk("R6 dma masked", dma_req, 0);
    wr(R_DMAM, 32'h4000_0000); cyc(2); chk("R6 dma on", dma_req, 1);
    wr(R_ST, 32'h4000_0000); cyc(3);
    chk("R6 irq off", irq, 0); chk("R6 dma off", dma_req, 0);
    wr(R_TRGM, 32'h0040_0000); chk("R6 trg idle", trig_out, 0);
    hall(3'b111); cyc(12); chk("R6 trg on V", trig_out, 1);
    hall(3'b101); cyc(12);
    wr(R_IRQM, 0); wr(R_DMAM, 0); wr(R_TRGM, 0); wr(R_ST, 32'hFFFF_FFFF);

    // timer
    rd(R_TMR, a); cyc(20); rd(R_TMR, b); chk("R13 timer step", b - a, 23);

    // snapshots disabled then enabled
    snap_a = 1'b1; cyc(1); snap_a = 1'b0;
    rd(R_SATMR, d); chk("R8 strobe ignored when off", d, 0);
    wr(R_CTRL, 32'h2);
    @(negedge clk); snap_a = 1'b1; @(negedge clk); snap_a = 1'b0;
    rd(R_SATMR, d); chk("R8 bank A captured", d != 0, 1);
    rd(R_SBTMR, d); chk("R8 bank B untouched", d, 0);
    @(negedge clk); snap_b = 1'b1; @(negedge clk); snap_b = 1'b0;
    rd(R_SBTMR, d); chk("R8 bank B captured", d != 0, 1);

    // read bank
    wr(R_CTRL, 32'h6); rd(R_RDTMR, a); chk("R7 load nonzero", a != 0, 1);
    rd(R_CTRL, d); chk("R7 self clear", d[2], 0);
    cyc(10); rd(R_RDTMR, b); chk("R7 bank stable", b, a);
    wr(R_RDM, 32'h0020_0000); hall(3'b100); cyc(12);
    rd(R_RDTMR, b); chk("R7 event load", b > a, 1);
    wr(R_RDM, 0);

    // counter hold
    wr(R_CTRL, 32'h3); cyc(5);
    rd(R_TMR, d); chk("R9 timer held", d, 0);
    rd(R_SATMR, d); chk("R9 snap held", d, 0);
    rd(R_RDTMR, d); chk("R9 read bank held", d, 0);
    wr(R_CTRL, 32'h2); cyc(10); rd(R_TMR, d); chk("R9 released", d != 0, 1);

    // history
    @(negedge clk); hall_in = 3'b000;
    repeat (40) @(negedge clk); hall_in = 3'b100;
    repeat (25) @(negedge clk); hall_in = 3'b000;
    cyc(12);
    rd(R_URISE, d); chk("R4 rise history", d, 40);
    rd(R_UFALL, d); chk("R4 fall history", d, 25);

    // stall watchdog
    wr(R_STTO, 50); wr(R_STEN, 1); wr(R_ST, 32'hFFFF_FFFF);
    cyc(80); rd(R_ST, d); chk("R10 stall flag", d[31], 1);
    wr(R_ST, 32'hFFFF_FFFF);
    for (int k = 0; k < 10; k++) begin hall(hall_in ^ 3'b001); cyc(19); end
    rd(R_ST, d); chk("R10 no stall while turning", d[31], 0);
    wr(R_STEN, 0);

    // early trigger
    wr(R_EARLY, 30);
    hall(3'b001); cyc(99); hall(3'b101); cyc(99);
    hall(3'b001); wr(R_ST, 32'hFFFF_FFFF); cyc(82);
    rd(R_ST, d); chk("R11 early fires", d[29], 1);
    cyc(12); wr(R_EARLY, 200);
    hall(3'b101); wr(R_ST, 32'hFFFF_FFFF); cyc(82);
    rd(R_ST, d); chk("R11 early silent when count too big", d[29], 0);

    // delay from change
    wr(R_DSEL, 0); wr(R_DLY, 40); cyc(60); wr(R_ST, 32'hFFFF_FFFF);
    hall(3'b001); cyc(20); rd(R_ST, d); chk("R12 delay not yet", d[28], 0);
    cyc(40); rd(R_ST, d); chk("R12 delay done", d[28], 1);

    // delay from early trigger
    wr(R_DSEL, 1); wr(R_DLY, 10); wr(R_EARLY, 30);
    hall(3'b101); cyc(99); hall(3'b001); cyc(99);
    hall(3'b101); wr(R_ST, 32'hFFFF_FFFF); cyc(50);
    rd(R_ST, d); chk("R12 select waits for early", d[28], 0);
    cyc(40); rd(R_ST, d);
    chk("R12 delay after early", d[28], 1); chk("R11 early seen", d[29], 1);

    // random direction walk
    s = 3'b101;
    for (int k = 0; k < 24; k++) begin
      bit fw;
      fw = 1'($urandom % 2);
      s = step(s, fw);
      hall(s); cyc(12); rd(R_UWORD, d);
      chk("R3 random dir", d[31], fw ? 1'b0 : 1'b1);
      chk("R2 random state", d[30:28], s);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule